// File: doc/BRIEF.md
# Packed Pixel Fade Compositor

This block mixes two streams of packed pixels. Each cycle it may take one 32-bit pixel from image A, one from image B and an 8-bit fade factor. Every pixel holds four byte components: red, green, blue and alpha. All four byte lanes run the same arithmetic side by side, and no lane affects another. The block computes B + fade·(A − B) in each lane, so a fade of zero gives image B and a fade of 255 gives very nearly image A.

The work is split into a fixed sequence of five registered steps:
1. Widen each byte to a 16-bit signed field.
2. Take the difference A − B.
3. Scale the difference by the fade factor and shift it right arithmetically by 8.
4. Add the B component back.
5. Clamp each lane to 0..255 and repack it into bytes.

A valid bit travels with the data, so the pipeline accepts a new pixel every cycle and delivers it five cycles later. The output word keeps its last result while no new result arrives.

Top module: `fade_blend_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `outValid` is 0 and `outPix` is 0.
- R2: A pixel offered with `inValid` high at a rising edge appears on `outPix` with `outValid` high right after the fifth rising edge that follows. A pixel may be offered on every cycle.
- R3: For each lane i, with bits [8i+7:8i] of every pixel word, the result is Bi + floor((Ai − Bi)·F / 256). F is `inFade` read as an unsigned number, and no lane borrows from or carries into another.
- R4: With a fade of 0, every output lane equals the matching lane of image B.
- R5: With a fade of 255, an output lane equals the A lane when A ≤ B in that lane, and A − 1 when A > B.
- R6: Every output lane lies between the A and B values of that lane, both included. No value ever wraps around.
- R7: A cycle with `inValid` low produces no result. Five cycles later `outValid` is low and `outPix` still holds the previous result, whatever the data and fade inputs carried.
- R8: Each pixel is blended with the fade value offered in the same cycle as that pixel, even when the fade changes on every cycle of a back-to-back stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks the pixel pair and fade on this cycle as valid |
| inPixA | input | 32 | Image A pixel, four byte lanes |
| inPixB | input | 32 | Image B pixel, four byte lanes |
| inFade | input | 8 | Unsigned blend factor, 255 is nearly one |
| outValid | output | 1 | High for one cycle per finished pixel |
| outPix | output | 32 | Blended pixel, held between results |

## Verification
A stage register that loses a pixel or gains an extra one makes `outValid` pulse at the wrong cycle. That difference shows up exactly five cycles after the input that caused it. A wrong sign extension or a wrong shift in one lane changes only that byte of the result. It shows first on pixels whose A lane is smaller than their B lane, and at fades near 0 and 255. A data register that does not honour the valid strobe lets `outPix` drift during gaps in the stream, one to five cycles after the gap begins.

// File: rtl/fade_pkg.sv
package fade_pkg;
  localparam int NUM_STAGES = 5;

  // one enable per pipeline step: unpack, subtract, scale, add, pack
  typedef struct packed {
    logic [NUM_STAGES-1:0] stageEn;
  } fade_strobe_t;
endpackage

// File: rtl/fade_ctrl.sv
module fade_ctrl
  import fade_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output fade_strobe_t strobes,
  output logic         outValid
);
  logic [NUM_STAGES-1:0] validPipe;
  logic [2:0]            cyclesSinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[NUM_STAGES-2:0], inValid};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cyclesSinceRst <= '0;
    end else if (cyclesSinceRst != 3'(NUM_STAGES)) begin
      cyclesSinceRst <= cyclesSinceRst + 3'd1;
    end
  end

  always_comb begin
    strobes.stageEn[0] = inValid;
    for (int s = 1; s < NUM_STAGES; s++) begin
      strobes.stageEn[s] = validPipe[s-1];
    end
  end

  assign outValid = validPipe[NUM_STAGES-1];

  // R2: every result was offered exactly five cycles earlier
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cyclesSinceRst == 3'(NUM_STAGES) && outValid) |-> $past(inValid, 5));

  // R7: an idle input cycle produces no result five cycles later
  p_idle_no_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cyclesSinceRst == 3'(NUM_STAGES) && !outValid) |-> !$past(inValid, 5));
endmodule

// File: rtl/fade_datapath.sv
module fade_datapath
  import fade_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int WIDE_W = 16,
  parameter int FADE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fade_strobe_t            strobes,
  input  logic [LANES*LANE_W-1:0] pixA,
  input  logic [LANES*LANE_W-1:0] pixB,
  input  logic [FADE_W-1:0]       fade,
  output logic [LANES*LANE_W-1:0] pixOut
);
  localparam int PROD_W = WIDE_W + FADE_W + 1;
  localparam logic signed [WIDE_W-1:0] LANE_MAX = WIDE_W'((1 << LANE_W) - 1);

  // fade travels with its pixel through the first two steps
  logic [FADE_W-1:0] fadeS1, fadeS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fadeS1 <= '0;
      fadeS2 <= '0;
    end else begin
      if (strobes.stageEn[0]) fadeS1 <= fade;
      if (strobes.stageEn[1]) fadeS2 <= fadeS1;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic signed [WIDE_W-1:0] unpA, unpB;
    logic signed [WIDE_W-1:0] diff, keepB2;
    logic signed [WIDE_W-1:0] scaled, keepB3;
    logic signed [WIDE_W-1:0] sum;
    logic [LANE_W-1:0]        packed8;
    logic signed [FADE_W:0]   fadeSigned;
    logic signed [PROD_W-1:0] product;
    logic signed [PROD_W-1:0] productShifted;
    logic [LANE_W-1:0]        satByte;

    assign fadeSigned     = signed'({1'b0, fadeS2});
    assign product        = PROD_W'(diff) * PROD_W'(fadeSigned);
    assign productShifted = product >>> FADE_W;

    always_comb begin
      if (sum < 0) begin
        satByte = '0;
      end else if (sum > LANE_MAX) begin
        satByte = LANE_MAX[LANE_W-1:0];
      end else begin
        satByte = sum[LANE_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        unpA    <= '0;
        unpB    <= '0;
        diff    <= '0;
        keepB2  <= '0;
        scaled  <= '0;
        keepB3  <= '0;
        sum     <= '0;
        packed8 <= '0;
      end else begin
        if (strobes.stageEn[0]) begin
          unpA <= signed'({{(WIDE_W-LANE_W){1'b0}}, pixA[lane*LANE_W +: LANE_W]});
          unpB <= signed'({{(WIDE_W-LANE_W){1'b0}}, pixB[lane*LANE_W +: LANE_W]});
        end
        if (strobes.stageEn[1]) begin
          diff   <= unpA - unpB;
          keepB2 <= unpB;
        end
        if (strobes.stageEn[2]) begin
          scaled <= WIDE_W'(productShifted);
          keepB3 <= keepB2;
        end
        if (strobes.stageEn[3]) begin
          sum <= keepB3 + scaled;
        end
        if (strobes.stageEn[4]) begin
          packed8 <= satByte;
        end
      end
    end

    assign pixOut[lane*LANE_W +: LANE_W] = packed8;

    // R4: a zero fade leaves nothing of the difference after scaling
    p_zero_fade_r4: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.stageEn[2] && fadeS2 == '0) |=> (scaled == '0));

    // R6: the sum handed to the pack step never needs clamping
    p_sum_in_range_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobes.stageEn[4] |-> (sum >= 0 && sum <= LANE_MAX));
  end

  // R7: the packed result only moves when a pixel reaches the last step
  p_hold_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stageEn[4] |=> $stable(pixOut));
endmodule

// File: rtl/fade_blend_top.sv
module fade_blend_top
  import fade_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int WIDE_W = 16,
  parameter int FADE_W = 8,
  localparam int PIX_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [PIX_W-1:0]  inPixA,
  input  logic [PIX_W-1:0]  inPixB,
  input  logic [FADE_W-1:0] inFade,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPix
);
  fade_strobe_t strobes;

  fade_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fade_datapath #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .WIDE_W (WIDE_W),
    .FADE_W (FADE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pixA    (inPixA),
    .pixB    (inPixB),
    .fade    (inFade),
    .pixOut  (outPix)
  );

  // R1: the output is quiet in the first cycle after reset is released
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outPix == '0));
endmodule

// File: tb/fade_blend_top_tb.sv
module fade_blend_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inPixA = '0;
  logic [31:0] inPixB = '0;
  logic [7:0]  inFade = '0;
  logic        outValid;
  logic [31:0] outPix;

  int checks = 0;
  int failures = 0;
  string curTag = "R2";
  bit finished = 0;

  // bench model of the five-step pipeline, from R2, R3 and R7
  bit          mv [1:5];
  logic [31:0] mp [1:5];
  logic [31:0] heldPix = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  fade_blend_top u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPixA(inPixA),
    .inPixB(inPixB), .inFade(inFade), .outValid(outValid), .outPix(outPix)
  );

  function automatic logic [31:0] blendRef(logic [31:0] a, logic [31:0] b, logic [7:0] f);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      int ai = int'(a[l*8 +: 8]);
      int bi = int'(b[l*8 +: 8]);
      int s = ((ai - bi) * int'(f)) >>> 8;
      int v = bi + s;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      r[l*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle from a negedge, advance the model, compare at the next negedge
  task automatic tick(bit v, logic [31:0] a, logic [31:0] b, logic [7:0] f);
    inValid = v; inPixA = a; inPixB = b; inFade = f;
    @(posedge clk);
    #1;
    for (int k = 5; k > 1; k--) begin
      mv[k] = mv[k-1];
      mp[k] = mp[k-1];
    end
    mv[1] = v;
    mp[1] = blendRef(a, b, f);
    if (mv[5]) heldPix = mp[5];
    @(negedge clk);
    check({curTag, " outValid"}, 32'(outValid), 32'(mv[5]));
    check({curTag, " outPix"}, outPix, heldPix);
  endtask

  task automatic flush();
    for (int k = 0; k < 5; k++) tick(1'b0, nextRand(), nextRand(), 8'(nextRand()));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid in reset", 32'(outValid), 32'd0);
    check("R1 pix in reset", outPix, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 32'(outValid), 32'd0);
    check("R1 pix after reset", outPix, 32'd0);
  endtask

  task automatic t_latency();
    int seen = 0;
    curTag = "R2";
    tick(1'b1, 32'h0102_0304, 32'h0506_0708, 8'd77);
    for (int k = 2; k <= 6; k++) begin
      if (outValid && seen == 0) seen = k - 1;
      tick(1'b0, 32'h0, 32'h0, 8'd0);
    end
    if (outValid && seen == 0) seen = 6;
    check("R2 latency cycles", 32'(seen), 32'd5);
  endtask

  task automatic t_zero_fade();
    curTag = "R4";
    for (int k = 0; k < 4; k++) tick(1'b1, nextRand(), 32'hA5_3C_00_FF + 32'(k), 8'd0);
    flush();
    check("R4 zero fade gives B", outPix, 32'hA5_3C_00_FF + 32'd3);
  endtask

  task automatic t_full_fade();
    curTag = "R5";
    tick(1'b1, 32'h10_80_FF_00, 32'h20_7F_00_FF, 8'd255);
    flush();
    check("R5 full fade", outPix, 32'h10_7F_FE_00);
  endtask

  task automatic t_lanes();
    curTag = "R3";
    tick(1'b1, 32'hC8_64_00_FF, 32'h64_64_C8_00, 8'd128);
    flush();
    check("R3 half fade lanes", outPix, 32'h96_64_64_7F);
  endtask

  task automatic t_stream();
    curTag = "R8";
    for (int k = 0; k < 24; k++) tick(1'b1, nextRand(), nextRand(), 8'(k * 11));
    flush();
  endtask

  task automatic t_bubbles();
    curTag = "R7";
    tick(1'b1, 32'h11_22_33_44, 32'h99_88_77_66, 8'd200);
    for (int k = 0; k < 12; k++) tick(k[0], nextRand(), nextRand(), 8'(nextRand()));
    flush();
    for (int k = 0; k < 6; k++) tick(1'b0, nextRand(), nextRand(), 8'(nextRand()));
  endtask

  task automatic t_range();
    logic [31:0] a, b, r;
    curTag = "R6";
    for (int k = 0; k < 10; k++) begin
      a = (k < 2) ? 32'hFF_00_FF_00 : nextRand();
      b = (k < 2) ? 32'h00_FF_00_FF : nextRand();
      tick(1'b1, a, b, (k == 0) ? 8'd255 : 8'(nextRand()));
      flush();
      r = outPix;
      for (int l = 0; l < 4; l++) begin
        logic [7:0] lo = (a[l*8 +: 8] < b[l*8 +: 8]) ? a[l*8 +: 8] : b[l*8 +: 8];
        logic [7:0] hi = (a[l*8 +: 8] < b[l*8 +: 8]) ? b[l*8 +: 8] : a[l*8 +: 8];
        check("R6 lane within A..B", 32'(r[l*8 +: 8] >= lo && r[l*8 +: 8] <= hi), 32'd1);
      end
    end
  endtask

  initial begin
    for (int k = 1; k <= 5; k++) begin
      mv[k] = 1'b0;
      mp[k] = '0;
    end
    t_reset();
    t_latency();
    t_zero_fade();
    t_full_fade();
    t_lanes();
    t_stream();
    t_bubbles();
    t_range();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule